// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the state side of taking an exception in a processor core. Each cycle it accepts at most one request: a general exception with a cause code, a debug exception, or a misaligned-access report. Each request carries the program counter of the faulting instruction and may carry a faulting virtual address. Every saved-state register that the request touches, and the processor status word, change together on one clock edge. In the next cycle a one-cycle strobe presents a vector code, which the fetch unit uses to pick the handler address.

Three things set the handler class: the exception-mode and user-mode bits of the status word, and whether the request is a debug request. A debug request is accepted only when the current interrupt level, which is a plain input, is below the configured debug level. The misaligned-access filter is set by two build options, and it either turns the report into a general exception with a fixed alignment cause or discards it. Software can overwrite the status word through a write port. Leaving an exception is handled elsewhere.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `status_q` is 0x1F, `vec_valid` is 0, `vec_sel` is 0, and all saved PC, cause and address outputs are 0. The status layout is: interrupt level in bits [3:0], exception mode in bit 4, user mode in bit 5, and bits [7:6] kept as written.
- R2: A general request (`req_kind`=0) taken while exception mode is clear writes `req_pc` into `ret_pc`. It selects the user vector (`vec_sel`=2) if user mode is set, and the kernel vector (`vec_sel`=1) if it is clear.
- R3: A general request taken while exception mode is already set selects the double vector (`vec_sel`=3). When `HAS_DBL_PC`=1 the PC goes to `dbl_pc` and `ret_pc` is left unchanged. When `HAS_DBL_PC`=0 the PC goes to `ret_pc`.
- R4: Every taken general request writes its cause into `fault_code` and sets exception mode. User mode and interrupt level are left unchanged.
- R5: A taken general request loads `fault_addr` from `req_addr` only when `req_has_addr` is 1. Otherwise `fault_addr` keeps its value.
- R6: A debug request (`req_kind`=1) is taken only when `cur_int_level` < `DBG_LEVEL`. When it is not taken, no state changes and no strobe follows.
- R7: A taken debug request does all of the following: writes `req_cause` into `dbg_reason`, writes the PC into the level-`DBG_LEVEL` slot of `lvl_pc_flat`, and writes the old status into the same slot of `lvl_st_flat`. It sets the interrupt level to `DBG_LEVEL`, sets exception mode, and selects `vec_sel`=4. Level L occupies slice [(L-2)*width +: width] of each flat bus.
- R8: A misaligned report (`req_kind`=2) is handled as a general request with cause `ALIGN_CAUSE` (default 9), and it always loads `fault_addr`. This happens only when `UNALIGN_TRAP_EN`=1 and `HW_ALIGN_EN`=0; otherwise the report is ignored. Kind 3 is always ignored.
- R9: `vec_valid` is 1 for exactly the one cycle after each taken request, with `vec_sel` valid alongside it. While the strobe is low, `vec_sel` reads 0.
- R10: A status write (`st_wr`) takes effect on the next edge unless a request is taken on that same edge. In that case the exception update wins and the written value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 general, 1 debug, 2 misaligned, 3 none |
| req_cause | input | CAUSE_W | Cause code of the request |
| req_pc | input | XLEN | PC of the faulting instruction |
| req_has_addr | input | 1 | Request carries a faulting address |
| req_addr | input | XLEN | Faulting virtual address |
| cur_int_level | input | 4 | Current interrupt level |
| st_wr | input | 1 | Status word write enable |
| st_wr_data | input | 8 | Status word write value |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_sel | output | 3 | Vector code: 1 kernel, 2 user, 3 double, 4 debug |
| status_q | output | 8 | Status word |
| ret_pc | output | XLEN | First-level saved PC |
| dbl_pc | output | XLEN | Double-exception saved PC |
| fault_code | output | CAUSE_W | Cause of the last general exception |
| fault_addr | output | XLEN | Faulting virtual address |
| dbg_reason | output | CAUSE_W | Cause of the last debug entry |
| lvl_pc_flat | output | 6*XLEN | Saved PC per level 2..7 |
| lvl_st_flat | output | 6*8 | Saved status per level 2..7 |

## Verification
The bench raises a general exception straight out of reset, while exception mode is still set. A design that ignored that bit would pick a kernel vector and overwrite `ret_pc`. It issues debug requests at an interrupt level equal to the debug level and at one level below it. An off-by-one gate would either trap on equality or refuse at the lower level. A second instance, built without the double-PC register and with hardware alignment handling, shows where the PC goes in that build and that the misaligned report is discarded. A status write issued in the same cycle as a taken exception checks that the exception update wins.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int LVL_W = 4;
    localparam int ST_W  = 8;

    typedef struct packed {
        logic [1:0]       spare;
        logic             user_mode;
        logic             exc_mode;
        logic [LVL_W-1:0] int_lvl;
    } status_t;

    localparam status_t STATUS_RST = '{spare: 2'b00, user_mode: 1'b0,
                                       exc_mode: 1'b1, int_lvl: {LVL_W{1'b1}}};

    typedef enum logic [1:0] {
        KIND_GENERAL  = 2'd0,
        KIND_DEBUG    = 2'd1,
        KIND_MISALIGN = 2'd2,
        KIND_NONE     = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    typedef struct packed {
        logic take;
        logic dbg;
        logic dbl;
        logic load_addr;
        logic use_align;
        vec_e vec;
    } act_t;

    function automatic vec_e general_vector(input logic exc_mode, input logic user_mode);
        if (exc_mode)       return VEC_DOUBLE;
        else if (user_mode) return VEC_USER;
        else                return VEC_KERNEL;
    endfunction

endpackage

// File: rtl/exc_decide.sv
`timescale 1ns/1ps
module exc_decide
    import exc_entry_pkg::*;
#(
    parameter int DBG_LEVEL       = 6,
    parameter bit UNALIGN_TRAP_EN = 1'b1,
    parameter bit HW_ALIGN_EN     = 1'b0
) (
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_has_addr,
    input  logic [LVL_W-1:0] cur_int_level,
    input  logic             exc_mode,
    input  logic             user_mode,
    output act_t             act
);
    localparam bit ALIGN_TRAPS = UNALIGN_TRAP_EN && !HW_ALIGN_EN;
    localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

    always_comb begin
        act = '{take: 1'b0, dbg: 1'b0, dbl: 1'b0, load_addr: 1'b0,
                use_align: 1'b0, vec: VEC_NONE};
        if (req_valid) begin
            case (req_kind_e'(req_kind))
                KIND_GENERAL: begin
                    act.take      = 1'b1;
                    act.dbl       = exc_mode;
                    act.load_addr = req_has_addr;
                    act.vec       = general_vector(exc_mode, user_mode);
                end
                KIND_MISALIGN: begin
                    act.take      = ALIGN_TRAPS;
                    act.dbl       = exc_mode;
                    act.load_addr = 1'b1;
                    act.use_align = 1'b1;
                    act.vec       = ALIGN_TRAPS ? general_vector(exc_mode, user_mode)
                                                : VEC_NONE;
                end
                KIND_DEBUG: begin
                    act.take = (cur_int_level < DBG_LVL_V);
                    act.dbg  = 1'b1;
                    act.vec  = (cur_int_level < DBG_LVL_V) ? VEC_DEBUG : VEC_NONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_gen_state.sv
`timescale 1ns/1ps
module exc_gen_state
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CAUSE_W    = 6,
    parameter bit HAS_DBL_PC = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  act_t               act,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    addr,
    output logic [XLEN-1:0]    ret_pc,
    output logic [XLEN-1:0]    dbl_pc,
    output logic [CAUSE_W-1:0] fault_code,
    output logic [XLEN-1:0]    fault_addr
);
    logic gen_take;
    assign gen_take = act.take && !act.dbg;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_code <= '0;
            fault_addr <= '0;
        end else if (gen_take) begin
            fault_code <= cause;
            if (act.load_addr) fault_addr <= addr;
        end
    end

    generate
        if (HAS_DBL_PC) begin : g_dbl
            logic [XLEN-1:0] dbl_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ret_pc <= '0;
                    dbl_q  <= '0;
                end else if (gen_take) begin
                    if (act.dbl) dbl_q  <= pc;
                    else         ret_pc <= pc;
                end
            end
            assign dbl_pc = dbl_q;

            a_r3_first_pc_kept: assert property (@(posedge clk) disable iff (rst)
                (gen_take && act.dbl) |=> $stable(ret_pc));
        end else begin : g_nodbl
            always_ff @(posedge clk) begin
                if (rst)           ret_pc <= '0;
                else if (gen_take) ret_pc <= pc;
            end
            assign dbl_pc = '0;
        end
    endgenerate

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (gen_take && !act.load_addr) |=> $stable(fault_addr));
endmodule

// File: rtl/exc_dbg_bank.sv
`timescale 1ns/1ps
module exc_dbg_bank
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DBG_LEVEL = 6,
    parameter int MAX_LEVEL = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  act_t                          act,
    input  logic [CAUSE_W-1:0]            cause,
    input  logic [XLEN-1:0]               pc,
    input  status_t                       old_status,
    output logic [CAUSE_W-1:0]            dbg_reason,
    output logic [(MAX_LEVEL-1)*XLEN-1:0] lvl_pc_flat,
    output logic [(MAX_LEVEL-1)*ST_W-1:0] lvl_st_flat
);
    localparam int NSLOT = MAX_LEVEL - 1;

    logic dbg_take;
    assign dbg_take = act.take && act.dbg;

    always_ff @(posedge clk) begin
        if (rst)           dbg_reason <= '0;
        else if (dbg_take) dbg_reason <= cause;
    end

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            if (s + 2 == DBG_LEVEL) begin : g_live
                logic [XLEN-1:0] pc_q;
                status_t         st_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pc_q <= '0;
                        st_q <= '0;
                    end else if (dbg_take) begin
                        pc_q <= pc;
                        st_q <= old_status;
                    end
                end
                assign lvl_pc_flat[s*XLEN +: XLEN] = pc_q;
                assign lvl_st_flat[s*ST_W +: ST_W] = st_q;

                a_r7_slot_hold: assert property (@(posedge clk) disable iff (rst)
                    !dbg_take |=> $stable(pc_q));
            end else begin : g_idle
                assign lvl_pc_flat[s*XLEN +: XLEN] = '0;
                assign lvl_st_flat[s*ST_W +: ST_W] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/exc_status.sv
`timescale 1ns/1ps
module exc_status
    import exc_entry_pkg::*;
#(
    parameter int DBG_LEVEL = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  act_t    act,
    input  logic    st_wr,
    input  status_t st_wr_data,
    output status_t status,
    output logic    vec_valid,
    output vec_e    vec_sel
);
    status_t nxt;

    always_comb begin
        nxt = status;
        if (act.take) begin
            nxt.exc_mode = 1'b1;
            if (act.dbg) nxt.int_lvl = LVL_W'(DBG_LEVEL);
        end else if (st_wr) begin
            nxt = st_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= STATUS_RST;
            vec_valid <= 1'b0;
            vec_sel   <= VEC_NONE;
        end else begin
            status    <= nxt;
            vec_valid <= act.take;
            vec_sel   <= act.take ? act.vec : VEC_NONE;
        end
    end

    a_r10_write_lost: assert property (@(posedge clk) disable iff (rst)
        (act.take && !act.dbg) |=> (status.int_lvl == $past(status.int_lvl)
                                    && status.user_mode == $past(status.user_mode)));
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN            = 32,
    parameter int CAUSE_W         = 6,
    parameter int DBG_LEVEL       = 6,
    parameter int MAX_LEVEL       = 7,
    parameter bit HAS_DBL_PC      = 1'b1,
    parameter bit UNALIGN_TRAP_EN = 1'b1,
    parameter bit HW_ALIGN_EN     = 1'b0,
    parameter int ALIGN_CAUSE     = 9
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [1:0]                    req_kind,
    input  logic [CAUSE_W-1:0]            req_cause,
    input  logic [XLEN-1:0]               req_pc,
    input  logic                          req_has_addr,
    input  logic [XLEN-1:0]               req_addr,
    input  logic [3:0]                    cur_int_level,
    input  logic                          st_wr,
    input  logic [7:0]                    st_wr_data,
    output logic                          vec_valid,
    output logic [2:0]                    vec_sel,
    output logic [7:0]                    status_q,
    output logic [XLEN-1:0]               ret_pc,
    output logic [XLEN-1:0]               dbl_pc,
    output logic [CAUSE_W-1:0]            fault_code,
    output logic [XLEN-1:0]               fault_addr,
    output logic [CAUSE_W-1:0]            dbg_reason,
    output logic [(MAX_LEVEL-1)*XLEN-1:0] lvl_pc_flat,
    output logic [(MAX_LEVEL-1)*8-1:0]    lvl_st_flat
);
    act_t               act;
    status_t            status;
    vec_e               vec_q;
    logic [CAUSE_W-1:0] eff_cause;

    assign eff_cause = act.use_align ? CAUSE_W'(ALIGN_CAUSE) : req_cause;

    exc_decide #(
        .DBG_LEVEL(DBG_LEVEL), .UNALIGN_TRAP_EN(UNALIGN_TRAP_EN), .HW_ALIGN_EN(HW_ALIGN_EN)
    ) u_decide (
        .req_valid(req_valid), .req_kind(req_kind), .req_has_addr(req_has_addr),
        .cur_int_level(cur_int_level), .exc_mode(status.exc_mode),
        .user_mode(status.user_mode), .act(act)
    );

    exc_gen_state #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DBL_PC(HAS_DBL_PC)
    ) u_gen (
        .clk(clk), .rst(rst), .act(act), .cause(eff_cause), .pc(req_pc),
        .addr(req_addr), .ret_pc(ret_pc), .dbl_pc(dbl_pc),
        .fault_code(fault_code), .fault_addr(fault_addr)
    );

    exc_dbg_bank #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DBG_LEVEL(DBG_LEVEL), .MAX_LEVEL(MAX_LEVEL)
    ) u_dbg (
        .clk(clk), .rst(rst), .act(act), .cause(req_cause), .pc(req_pc),
        .old_status(status), .dbg_reason(dbg_reason),
        .lvl_pc_flat(lvl_pc_flat), .lvl_st_flat(lvl_st_flat)
    );

    exc_status #(.DBG_LEVEL(DBG_LEVEL)) u_status (
        .clk(clk), .rst(rst), .act(act), .st_wr(st_wr),
        .st_wr_data(status_t'(st_wr_data)), .status(status),
        .vec_valid(vec_valid), .vec_sel(vec_q)
    );

    assign vec_sel  = vec_q;
    assign status_q = status;

    a_r4_mode_set: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> status.exc_mode);

    a_r6_dbg_gate: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1 && cur_int_level >= 4'(DBG_LEVEL)) |=> !vec_valid);

    a_r3_double_vec: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && status.exc_mode) |=> (vec_sel == 3'd3));

    a_r2_user_vec: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && !status.exc_mode && status.user_mode)
            |=> (vec_sel == 3'd2));

    a_r7_dbg_level: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_sel == 3'd4) |-> (status.int_lvl == 4'(DBG_LEVEL)));

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !$past(req_valid)) |-> 1'b0);

    a_r8_align_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && HW_ALIGN_EN) |=> !vec_valid);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam int XLEN = 32;
    localparam int CW   = 6;
    localparam int DBGL = 6;
    localparam int NS   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [1:0]      req_kind = 2'd0;
    logic [CW-1:0]   req_cause = '0;
    logic [XLEN-1:0] req_pc = '0;
    logic            req_has_addr = 1'b0;
    logic [XLEN-1:0] req_addr = '0;
    logic [3:0]      cur_int_level = 4'd0;
    logic            st_wr = 1'b0;
    logic [7:0]      st_wr_data = 8'd0;

    logic            a_vv, b_vv;
    logic [2:0]      a_vs, b_vs;
    logic [7:0]      a_st, b_st;
    logic [XLEN-1:0] a_rpc, b_rpc, a_dpc, b_dpc, a_fa, b_fa;
    logic [CW-1:0]   a_fc, b_fc, a_dr, b_dr;
    logic [NS*XLEN-1:0] a_lpc, b_lpc;
    logic [NS*8-1:0]    a_lst, b_lst;

    exc_entry_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_cause(req_cause), .req_pc(req_pc), .req_has_addr(req_has_addr),
        .req_addr(req_addr), .cur_int_level(cur_int_level), .st_wr(st_wr),
        .st_wr_data(st_wr_data), .vec_valid(a_vv), .vec_sel(a_vs), .status_q(a_st),
        .ret_pc(a_rpc), .dbl_pc(a_dpc), .fault_code(a_fc), .fault_addr(a_fa),
        .dbg_reason(a_dr), .lvl_pc_flat(a_lpc), .lvl_st_flat(a_lst)
    );

    exc_entry_ctrl #(.HAS_DBL_PC(1'b0), .HW_ALIGN_EN(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_cause(req_cause), .req_pc(req_pc), .req_has_addr(req_has_addr),
        .req_addr(req_addr), .cur_int_level(cur_int_level), .st_wr(st_wr),
        .st_wr_data(st_wr_data), .vec_valid(b_vv), .vec_sel(b_vs), .status_q(b_st),
        .ret_pc(b_rpc), .dbl_pc(b_dpc), .fault_code(b_fc), .fault_addr(b_fa),
        .dbg_reason(b_dr), .lvl_pc_flat(b_lpc), .lvl_st_flat(b_lst)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] kind, input logic [CW-1:0] cause,
                         input logic [31:0] pc, input logic has_a,
                         input logic [31:0] addr, input logic [3:0] lvl);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_cause = cause; req_pc = pc;
        req_has_addr = has_a; req_addr = addr; cur_int_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_status(input logic [7:0] v);
        @(negedge clk);
        st_wr = 1'b1; st_wr_data = v;
        @(negedge clk);
        st_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", 32'(a_st), 32'h1F);
        chk("R1 vec_valid", 32'(a_vv), 0);
        chk("R1 vec_sel", 32'(a_vs), 0);
        chk("R1 ret_pc", a_rpc, 0);
        chk("R1 fault_code", 32'(a_fc), 0);
    endtask

    task automatic t_double_from_reset;
        issue(2'd0, 6'd5, 32'h1000, 1'b0, 32'h0, 4'd0);
        chk("R3 vec double", 32'(a_vs), 3);
        chk("R9 strobe high", 32'(a_vv), 1);
        chk("R3 dbl_pc", a_dpc, 32'h1000);
        chk("R3 ret_pc kept", a_rpc, 0);
        chk("R4 fault_code", 32'(a_fc), 5);
        chk("R3 no-dbl build ret_pc", b_rpc, 32'h1000);
        chk("R3 no-dbl build vec", 32'(b_vs), 3);
        @(negedge clk);
        chk("R9 strobe drops", 32'(a_vv), 0);
        chk("R9 vec_sel idle", 32'(a_vs), 0);
    endtask

    task automatic t_kernel;
        write_status(8'h03);
        chk("R10 status written", 32'(a_st), 32'h03);
        issue(2'd0, 6'd7, 32'h2000, 1'b1, 32'hABCD0000, 4'd0);
        chk("R2 kernel vec", 32'(a_vs), 1);
        chk("R2 ret_pc", a_rpc, 32'h2000);
        chk("R4 status mode set", 32'(a_st), 32'h13);
        chk("R5 fault_addr loaded", a_fa, 32'hABCD0000);
        chk("R4 fault_code", 32'(a_fc), 7);
    endtask

    task automatic t_user;
        write_status(8'h25);
        issue(2'd0, 6'd12, 32'h3000, 1'b0, 32'h55555555, 4'd0);
        chk("R2 user vec", 32'(a_vs), 2);
        chk("R2 ret_pc", a_rpc, 32'h3000);
        chk("R4 keeps user/level", 32'(a_st), 32'h35);
        chk("R5 fault_addr held", a_fa, 32'hABCD0000);
    endtask

    task automatic t_debug;
        write_status(8'h05);
        issue(2'd1, 6'd3, 32'h4000, 1'b0, 32'h0, 4'd6);
        chk("R6 blocked no strobe", 32'(a_vv), 0);
        chk("R6 blocked status", 32'(a_st), 32'h05);
        chk("R6 blocked slot", a_lpc[(DBGL-2)*XLEN +: XLEN], 0);
        chk("R6 blocked reason", 32'(a_dr), 0);
        issue(2'd1, 6'd3, 32'h4000, 1'b0, 32'h0, 4'd5);
        chk("R7 vec debug", 32'(a_vs), 4);
        chk("R7 reason", 32'(a_dr), 3);
        chk("R7 slot pc", a_lpc[(DBGL-2)*XLEN +: XLEN], 32'h4000);
        chk("R7 slot status", 32'(a_lst[(DBGL-2)*8 +: 8]), 32'h05);
        chk("R7 new status", 32'(a_st), 32'h16);
        chk("R7 other slot idle", a_lpc[(DBGL-3)*XLEN +: XLEN], 0);
        chk("R7 ret_pc untouched", a_rpc, 32'h3000);
    endtask

    task automatic t_misalign;
        write_status(8'h02);
        issue(2'd2, 6'h3F, 32'h5000, 1'b0, 32'h1235, 4'd0);
        chk("R8 trap vec", 32'(a_vs), 1);
        chk("R8 align cause", 32'(a_fc), 9);
        chk("R8 addr", a_fa, 32'h1235);
        chk("R8 ret_pc", a_rpc, 32'h5000);
        chk("R8 hw-align ignored strobe", 32'(b_vv), 0);
        chk("R8 hw-align status kept", 32'(b_st), 32'h02);
        chk("R8 hw-align cause kept", 32'(b_fc), 12);
        issue(2'd3, 6'd1, 32'h5100, 1'b1, 32'h9, 4'd0);
        chk("R8 kind3 ignored", 32'(a_vv), 0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        st_wr = 1'b1; st_wr_data = 8'h20;
        req_valid = 1'b1; req_kind = 2'd0; req_cause = 6'd4; req_pc = 32'h6000;
        req_has_addr = 1'b0;
        @(negedge clk);
        st_wr = 1'b0; req_valid = 1'b0;
        chk("R10 write dropped", 32'(a_st), 32'h12);
        chk("R3 collision dbl_pc", a_dpc, 32'h6000);
        write_status(8'h20);
        chk("R10 later write", 32'(a_st), 32'h20);
    endtask

    bit done = 1'b0;
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_double_from_reset();
        t_kernel();
        t_user();
        t_debug();
        t_misalign();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule